// File: doc/BRIEF.md
# Retirement Fingerprint Accumulator

This block compresses the architectural effects of retiring instructions into a 16-bit signature, one for each checkpoint interval. Two lockstep processors can then confirm that they executed the same work by exchanging two bytes per interval instead of every state update. In each cycle the retirement stage can offer one update record. The record carries an optional destination register result and a memory effective address. For a store it also carries the written data. The block folds the present fields into a running cyclic redundancy check.

A checkpoint-close strobe ends the interval. The block publishes the finished signature with a one-cycle valid pulse and restarts the accumulator from its initial value. The program counter, decoded instruction bits, condition flags and other internal pipeline state are never offered to the block, so they never reach the signature.

The update input is a valid/ready stream. The block raises ready on the first clock edge after reset and keeps it high. It therefore never applies back-pressure, and a record is taken in every cycle where valid is high. The close strobe and the fingerprint output are plain control pins.

Top module: `retire_fingerprint`

## Requirements
- R1: While reset is asserted, fp_valid is 0, fp_value is 0x0000 and upd_ready is 0. The accumulator restarts at 0xFFFF.
- R2: The signature is a non-reflected CRC-16. The generator is x^16+x^12+x^5+1 (0x1021) and the initial value is 0xFFFF, with no final XOR. Each field is shifted in as one 64-bit word, most significant bit first.
- R3: When a taken record has upd_has_result=1, the register result is folded in.
- R4: When upd_is_mem=1, the effective address is folded in. When upd_is_mem=1 and upd_is_store=1, the store data is also folded in. When upd_is_store=1 and upd_is_mem=0, the record has the same effect as upd_is_store=0.
- R5: Within one record the fields are folded in a fixed order: the result first, then the address, then the store data.
- R6: A field narrower than 64 bits is zero-extended at the top before it is folded in.
- R7: fp_valid goes high for exactly the one cycle after a cycle with close_strobe=1. fp_value holds the published signature until the next close.
- R8: A record taken in the same cycle as close_strobe belongs to the closing signature. The next interval starts again from 0xFFFF.
- R9: An interval with no folded fields closes with the signature 0xFFFF.
- R10: With upd_valid=0 the record inputs have no effect. A taken record with no field flag set leaves the signature unchanged.
- R11: Two streams that are identical except for one flipped bit close with different signatures. Identical streams close with identical signatures.
- R12: Once out of reset, upd_ready stays 1 and a record is taken in every cycle where upd_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | An update record is offered |
| upd_ready | output | 1 | The block takes records (high after reset) |
| upd_has_result | input | 1 | The record carries a register result |
| upd_result | input | DATA_W | Destination register result |
| upd_is_mem | input | 1 | The record is a load or store |
| upd_is_store | input | 1 | The memory operation is a store |
| upd_addr | input | ADDR_W | Effective address |
| upd_store_data | input | DATA_W | Data written by a store |
| close_strobe | input | 1 | End the checkpoint interval |
| fp_valid | output | 1 | One-cycle pulse: fp_value holds a new signature |
| fp_value | output | CRC_W | Signature of the closed interval |

## Verification
The bench builds the block with 64-bit results and store data and a 48-bit address. The 48-bit address makes every memory record pass through the zero-extension path. With the 16-bit 0x1021 generator, every signature can be compared against a plain bit-serial reference shift register. Directed streams cover each combination of field flags, including a store flag without the memory flag, a close in the same cycle as an update, back-to-back closes, and swapped field contents. A single-bit flip in an otherwise repeated stream shows that the signature separates the two. A long random phase with random closes is compared against the reference in every cycle.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int NUM_FIELDS = 3;
  // Slot order is the folding order within a record.
  typedef enum logic [1:0] {
    SLOT_RESULT = 2'd0,
    SLOT_ADDR   = 2'd1,
    SLOT_STDATA = 2'd2
  } slot_e;
endpackage

// File: rtl/fp_field_sel.sv
module fp_field_sel
  import fp_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 48,
  parameter int FIELD_W = 64
) (
  input  logic                                  has_result,
  input  logic                                  is_mem,
  input  logic                                  is_store,
  input  logic [DATA_W-1:0]                     result,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     st_data,
  output logic [NUM_FIELDS-1:0]                 fld_en,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]    fld_word
);
  always_comb begin
    fld_en = '0;
    fld_word = '0;
    fld_en[SLOT_RESULT]   = has_result;
    fld_word[SLOT_RESULT] = FIELD_W'(result);
    fld_en[SLOT_ADDR]     = is_mem;
    fld_word[SLOT_ADDR]   = FIELD_W'(addr);
    fld_en[SLOT_STDATA]   = is_mem & is_store;
    fld_word[SLOT_STDATA] = FIELD_W'(st_data);
  end
endmodule

// File: rtl/fp_crc_fold.sv
module fp_crc_fold #(
  parameter int          CRC_W   = 16,
  parameter int          FIELD_W = 64,
  parameter logic [15:0] POLY    = 16'h1021
) (
  input  logic               en,
  input  logic [CRC_W-1:0]   crc_in,
  input  logic [FIELD_W-1:0] word,
  output logic [CRC_W-1:0]   crc_out
);
  localparam int DIV_W = FIELD_W + CRC_W;
  localparam logic [DIV_W-1:0] GEN = DIV_W'({1'b1, POLY[CRC_W-1:0]});

  // Remainder of (crc * x^FIELD_W + word * x^CRC_W) modulo the generator.
  function automatic logic [CRC_W-1:0] remainder(input logic [CRC_W-1:0] c,
                                                 input logic [FIELD_W-1:0] w);
    logic [DIV_W-1:0] v;
    v = {w, {CRC_W{1'b0}}} ^ {c, {FIELD_W{1'b0}}};
    for (int i = DIV_W - 1; i >= CRC_W; i--) begin
      if (v[i]) v = v ^ (GEN << (i - CRC_W));
    end
    return v[CRC_W-1:0];
  endfunction

  always_comb crc_out = en ? remainder(crc_in, word) : crc_in;
endmodule

// File: rtl/fp_sig_reg.sv
module fp_sig_reg #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] INIT  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close,
  input  logic [CRC_W-1:0] crc_nxt,
  output logic [CRC_W-1:0] crc_q,
  output logic             ready,
  output logic             fp_valid,
  output logic [CRC_W-1:0] fp_value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q    <= INIT[CRC_W-1:0];
      ready    <= 1'b0;
      fp_valid <= 1'b0;
      fp_value <= '0;
    end else begin
      ready    <= 1'b1;
      fp_valid <= close;
      if (close) begin
        fp_value <= crc_nxt;
        crc_q    <= INIT[CRC_W-1:0];
      end else begin
        crc_q    <= crc_nxt;
      end
    end
  end
endmodule

// File: rtl/retire_fingerprint.sv
module retire_fingerprint
  import fp_pkg::*;
#(
  parameter int          DATA_W  = 64,
  parameter int          ADDR_W  = 48,
  parameter int          FIELD_W = 64,
  parameter int          CRC_W   = 16,
  parameter logic [15:0] POLY    = 16'h1021,
  parameter logic [15:0] INIT    = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic              upd_has_result,
  input  logic [DATA_W-1:0] upd_result,
  input  logic              upd_is_mem,
  input  logic              upd_is_store,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_store_data,
  input  logic              close_strobe,
  output logic              fp_valid,
  output logic [CRC_W-1:0]  fp_value
);
  logic                               take;
  logic [NUM_FIELDS-1:0]              fld_en;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_word;
  logic [NUM_FIELDS:0][CRC_W-1:0]     chain;
  logic [CRC_W-1:0]                   crc_q;

  assign take = upd_valid & upd_ready;

  fp_field_sel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_sel (
    .has_result (upd_has_result),
    .is_mem     (upd_is_mem),
    .is_store   (upd_is_store),
    .result     (upd_result),
    .addr       (upd_addr),
    .st_data    (upd_store_data),
    .fld_en     (fld_en),
    .fld_word   (fld_word)
  );

  assign chain[0] = crc_q;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fold
    fp_crc_fold #(.CRC_W(CRC_W), .FIELD_W(FIELD_W), .POLY(POLY)) u_fold (
      .en      (take & fld_en[g]),
      .crc_in  (chain[g]),
      .word    (fld_word[g]),
      .crc_out (chain[g+1])
    );
  end

  fp_sig_reg #(.CRC_W(CRC_W), .INIT(INIT)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .close    (close_strobe),
    .crc_nxt  (chain[NUM_FIELDS]),
    .crc_q    (crc_q),
    .ready    (upd_ready),
    .fp_valid (fp_valid),
    .fp_value (fp_value)
  );
endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] INIT  = 16'hFFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic             close_strobe,
  input logic             fp_valid,
  input logic [CRC_W-1:0] fp_value,
  input logic [CRC_W-1:0] crc_q
);
  // R7: the pulse follows a close, and only a close
  a_r7_pulse_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    close_strobe |=> fp_valid);
  a_r7_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !close_strobe |=> !fp_valid);
  // R7: published value is held between closes
  a_r7_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    !close_strobe |=> $stable(fp_value));
  // R12: ready never drops once raised
  a_r12_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ready |=> upd_ready);
  // R10: idle cycles leave the accumulator alone
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !close_strobe) |=> $stable(crc_q));
  // R8, R9: back-to-back closes with no update publish the initial value
  a_r8_restart_init: assert property (@(posedge clk) disable iff (!rst_n)
    (close_strobe && !upd_valid) ##1 (close_strobe && !upd_valid) |=> fp_value == INIT[CRC_W-1:0]);
  // R7: published value is never unknown
  a_r7_value_known: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid |-> !$isunknown(fp_value));
endmodule

bind retire_fingerprint fp_checker #(.CRC_W(CRC_W), .INIT(INIT)) u_fp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .upd_valid    (upd_valid),
  .upd_ready    (upd_ready),
  .close_strobe (close_strobe),
  .fp_valid     (fp_valid),
  .fp_value     (fp_value),
  .crc_q        (crc_q)
);

// File: tb/retire_fingerprint_bench.sv
module retire_fingerprint_bench;
  localparam int DW = 64;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          upd_valid, upd_ready, upd_has_result, upd_is_mem, upd_is_store;
  logic [DW-1:0] upd_result, upd_store_data;
  logic [AW-1:0] upd_addr;
  logic          close_strobe, fp_valid;
  logic [15:0]   fp_value;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_crc, m_fp;
  logic        m_fv, m_rdy;

  always #5 clk = ~clk;

  retire_fingerprint u_retire_fingerprint (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_has_result(upd_has_result), .upd_result(upd_result),
    .upd_is_mem(upd_is_mem), .upd_is_store(upd_is_store), .upd_addr(upd_addr),
    .upd_store_data(upd_store_data), .close_strobe(close_strobe),
    .fp_valid(fp_valid), .fp_value(fp_value)
  );

  // Bit-serial reference: one bit per step, MSB first.
  function automatic logic [15:0] ser(input logic [15:0] c, input logic [63:0] w);
    for (int i = 63; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ w[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle's inputs at a falling edge, advance the model at the
  // rising edge, compare outputs at the next falling edge.
  task automatic cyc(input string tag, input logic v, input logic hr, input logic [63:0] res,
                     input logic mem, input logic st, input logic [47:0] a,
                     input logic [63:0] sd, input logic cl);
    logic [15:0] n;
    upd_valid = v; upd_has_result = hr; upd_result = res; upd_is_mem = mem;
    upd_is_store = st; upd_addr = a; upd_store_data = sd; close_strobe = cl;
    @(posedge clk);
    n = m_crc;
    if (v && m_rdy) begin
      if (hr) n = ser(n, res);
      if (mem) n = ser(n, {16'h0, a});
      if (mem && st) n = ser(n, sd);
    end
    m_fv = cl;
    if (cl) begin m_fp = n; m_crc = 16'hFFFF; end
    else m_crc = n;
    m_rdy = 1'b1;
    @(negedge clk);
    chk({tag, " fp_valid"}, 32'(fp_valid), 32'(m_fv));
    chk({tag, " fp_value"}, 32'(fp_value), 32'(m_fp));
    chk({tag, " upd_ready"}, 32'(upd_ready), 32'(m_rdy));
  endtask

  task automatic idle(input string tag, input logic cl);
    cyc(tag, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 48'h0, 64'h0, cl);
  endtask

  // Fixed stream of four records, with an optional flipped bit in the store data.
  task automatic stream(input string tag, input logic [63:0] flip);
    cyc(tag, 1, 1, 64'h0123_4567_89AB_CDEF, 0, 0, 48'h0, 64'h0, 0);
    cyc(tag, 1, 1, 64'h0000_0000_0000_0042, 1, 0, 48'h7FFF_0000_1000, 64'h0, 0);
    cyc(tag, 1, 0, 64'h0, 1, 1, 48'h7FFF_0000_1008, 64'hDEAD_BEEF_0000_0001 ^ flip, 0);
    cyc(tag, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 48'h0, 64'h0, 1);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] fa, fb, fc;
    rst_n = 1'b0;
    upd_valid = 0; upd_has_result = 0; upd_result = 0; upd_is_mem = 0;
    upd_is_store = 0; upd_addr = 0; upd_store_data = 0; close_strobe = 0;
    m_crc = 16'hFFFF; m_fp = 16'h0; m_fv = 0; m_rdy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 fp_valid in reset", 32'(fp_valid), 32'd0);
    chk("R1 fp_value in reset", 32'(fp_value), 32'd0);
    chk("R1 upd_ready in reset", 32'(upd_ready), 32'd0);
    rst_n = 1'b1;
    idle("R12 ready after reset", 0);
    // R9: empty interval
    idle("R9 empty close", 1);
    chk("R9 empty value", 32'(fp_value), 32'h0000_FFFF);
    idle("R7 pulse ends", 0);
    // R3: register result only
    cyc("R3 result", 1, 1, 64'h1, 0, 0, 48'h0, 64'h0, 1);
    chk("R2 known single result", 32'(fp_value), 32'(ser(16'hFFFF, 64'h1)));
    // R4: load address, store address+data, store flag without memory flag
    cyc("R4 load", 1, 0, 64'h0, 1, 0, 48'hABCD_0000_0040, 64'h5555, 0);
    cyc("R4 store", 1, 0, 64'h0, 1, 1, 48'hABCD_0000_0080, 64'h1234_5678, 0);
    cyc("R4 store flag no mem", 1, 1, 64'h77, 0, 1, 48'hFFFF_FFFF_FFFF, 64'hFFFF, 1);
    // R6: high address bits zero-extended
    cyc("R6 pad", 1, 0, 64'h0, 1, 0, 48'hFFFF_FFFF_FFFF, 64'h0, 1);
    chk("R6 pad value", 32'(fp_value), 32'(ser(16'hFFFF, 64'h0000_FFFF_FFFF_FFFF)));
    // R10: invalid records and flagless records are ignored
    cyc("R10 junk not valid", 0, 1, 64'hAAAA, 1, 1, 48'h1234, 64'hBBBB, 0);
    cyc("R10 valid no flags", 1, 0, 64'hAAAA, 0, 0, 48'h1234, 64'hBBBB, 0);
    idle("R10 close", 1);
    chk("R10 untouched", 32'(fp_value), 32'h0000_FFFF);
    // R5: order matters: result then address
    cyc("R5 a", 1, 1, 64'h11, 1, 0, 48'h22, 64'h0, 1);
    fa = fp_value;
    cyc("R5 b", 1, 1, 64'h22, 1, 0, 48'h11, 64'h0, 1);
    chk("R5 order distinguishes", 32'(fa != fp_value), 32'd1);
    // R8: close with update, then restart
    cyc("R8 pre", 1, 1, 64'h5, 0, 0, 48'h0, 64'h0, 0);
    cyc("R8 same cycle", 1, 1, 64'h6, 1, 1, 48'h8, 64'h9, 1);
    cyc("R8 restart", 1, 1, 64'h6, 0, 0, 48'h0, 64'h0, 1);
    chk("R8 restart value", 32'(fp_value), 32'(ser(16'hFFFF, 64'h6)));
    idle("R8 b2b 1", 1);
    idle("R8 b2b 2", 1);
    // R7: hold between closes
    repeat (3) idle("R7 hold", 0);
    // R11: repeatability and single-bit sensitivity
    stream("R11 base", 64'h0);
    fa = fp_value;
    stream("R11 repeat", 64'h0);
    fb = fp_value;
    stream("R11 flip", 64'h0000_0100_0000_0000);
    fc = fp_value;
    chk("R11 repeat equal", 32'(fa == fb), 32'd1);
    chk("R11 flip differs", 32'(fa != fc), 32'd1);
    // R2/R12: random phase
    for (int k = 0; k < 400; k++) begin
      cyc("R2 random", 1'($urandom), 1'($urandom), {$urandom, $urandom}, 1'($urandom),
          1'($urandom), {16'($urandom), $urandom}, {$urandom, $urandom},
          ($urandom % 7) == 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule